// File: doc/BRIEF.md
# Sine and Square Waveform Generator

This block emits one signed 8-bit waveform sample on every clock. An internal phase counter advances by one each cycle and wraps around. A single select input picks the waveform. In sine mode the phase indexes a one-period table of signed sine samples. In square mode the phase is compared against the half-period point, and one of two fixed levels is emitted. The output feeds a converter or a downstream datapath that expects a new sample on every cycle.

Reset enters on an active-low pin that takes effect asynchronously. Release is made synchronous by a short local shift register whose lowest stage acts as the block's internal clear. For several clocks after the pin returns high, that clear keeps the phase at zero and the output at zero. The first live sample therefore always starts at phase 0.

The sine table is computed when the design is elaborated, with fixed-point arithmetic. Its entries equal 127·sin(2π·p/256) rounded to the nearest integer.

Top module: `dual_wave_gen`

## Requirements
- R1: While rst_n is low, and for exactly 4 rising clock edges after it returns high, sample_out is 0 at every edge and the phase is held at 0.
- R2: A low pulse on rst_n that starts and ends between two rising edges still forces sample_out to 0 for the next 4 edges, after which output restarts from phase 0.
- R3: The phase counter is 8 bits, steps by +1 per clock and wraps from 255 to 0. The sample registered at an edge reflects the phase held before that edge, so the first sample after the clear window corresponds to phase 0.
- R4: mode_sel = 0 selects square mode and mode_sel = 1 selects sine mode. The value present at a rising edge decides that edge's sample, and the mode may change on any cycle without disturbing the phase sequence.
- R5: In square mode the sample is -127 (0x81) when the phase is below 128 and +127 (0x7F) when the phase is 128 or higher.
- R6: In sine mode the sample, read as two's complement, is within 1 of 127·sin(2π·p/256) for phase p.
- R7: The sine sample is exactly 0 at phases 0 and 128, +127 at phase 64 and -127 at phase 192.
- R8: The sine samples satisfy s(p) = -s(p+128) for p in 1..127, and s(p) = s(128-p) for p in 1..63.
- R9: sample_out never carries the value -128 (0x80).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; one sample per rising edge |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released through the local synchronizer |
| mode_sel | input | 1 | 0 = square, 1 = sine |
| sample_out | output | 8 | Registered two's-complement waveform sample |

## Verification
On every cycle, assertions check the following:
- the phase steps by one when the internal clear was inactive on the previous edge, and is zero after a cleared edge;
- the output is zero after a cleared edge;
- in square mode the level agrees with the previous phase;
- the output never carries the most negative code.

Some behaviours need the bench's scenarios instead:
- the length of the clear window after a release, and the glitch-shaped reset pulse that falls between edges;
- the tolerance of each sine entry against a real-valued sine;
- the exact peaks and zeros, and the half-period and quarter-period symmetry across a captured period;
- mode changes on arbitrary cycles.

// File: rtl/wg_pkg.sv
// Package: shared types and elaboration-time math for the waveform generator.
// Assumes every function is evaluated only on constant arguments (table build).
package wg_pkg;

    typedef enum logic {
        MODE_SQUARE = 1'b0,
        MODE_SINE   = 1'b1
    } wave_mode_e;

    localparam int FRAC_BITS = 30;
    localparam longint ONE_Q = 64'sd1 << FRAC_BITS;
    localparam longint PI_Q  = 64'sd3373259426;   // pi scaled by 2^30

    // sin(pi/2 * k / 2^qbits) in Q30, Horner form of the odd Taylor series
    function automatic longint quarter_sine_q(input longint k, input int qbits);
        longint x;
        longint x2;
        longint t;
        x  = (k * PI_Q) >>> (qbits + 1);
        x2 = (x * x) >>> FRAC_BITS;
        t  = ONE_Q;
        t  = ONE_Q - ((x2 * t) >>> FRAC_BITS) / 110;
        t  = ONE_Q - ((x2 * t) >>> FRAC_BITS) / 72;
        t  = ONE_Q - ((x2 * t) >>> FRAC_BITS) / 42;
        t  = ONE_Q - ((x2 * t) >>> FRAC_BITS) / 20;
        t  = ONE_Q - ((x2 * t) >>> FRAC_BITS) / 6;
        return (x * t) >>> FRAC_BITS;
    endfunction

    // Full-period sample: round(amp * sin(2*pi*idx / 2^phase_w)) via quadrant folding
    function automatic int sine_sample(input int idx, input int phase_w, input int amp);
        int     qbits;
        int     quarter;
        int     quad;
        int     rem;
        int     k;
        longint mag;
        qbits   = phase_w - 2;
        quarter = 1 << qbits;
        quad    = (idx >> qbits) & 3;
        rem     = idx & (quarter - 1);
        k       = ((quad & 1) != 0) ? (quarter - rem) : rem;
        mag     = (longint'(amp) * quarter_sine_q(longint'(k), qbits)
                   + (64'sd1 << (FRAC_BITS - 1))) >>> FRAC_BITS;
        return ((quad & 2) != 0) ? -int'(mag) : int'(mag);
    endfunction

endpackage

// File: rtl/wg_reset_sync.sv
// Module: local reset synchronizer.
// Sets all stages asynchronously when rst_n falls, then shifts a zero in from
// the top on each clock. The lowest stage is the block-wide synchronous clear.
// Assumes rst_n may change at any time relative to clk.
module wg_reset_sync #(
    parameter int STAGES = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic clr_o
);

    logic [STAGES-1:0] stage_q;

    // Purpose: async set on reset, drain toward zero one stage per clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '1;
        end else begin
            stage_q <= {1'b0, stage_q[STAGES-1:1]};
        end
    end

    assign clr_o = stage_q[0];

endmodule

// File: rtl/wg_phase_counter.sv
// Module: free-running phase accumulator.
// Steps by one every clock, wraps naturally at 2^PHASE_W, clears synchronously.
// Assumes clr_i is already synchronous to clk.
module wg_phase_counter #(
    parameter int PHASE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    output logic [PHASE_W-1:0] phase_o
);

    logic [PHASE_W-1:0] phase_q;

    // Purpose: advance phase or hold it at zero under the local clear
    always_ff @(posedge clk) begin
        if (clr_i) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign phase_o = phase_q;

    // R3: an edge without clear leaves the phase one above its previous value
    assert_phase_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr_i) |-> phase_q == $past(phase_q) + 1'b1);

    // R1: an edge taken under clear leaves the phase at zero
    assert_phase_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_i) |-> phase_q == '0);

endmodule

// File: rtl/wg_sine_rom.sv
// Module: one-period signed sine lookup.
// Entries are built at elaboration from the package's fixed-point series, so
// no literal table exists in the source. Read is purely combinational.
// Assumes PHASE_W >= 3 so that a quarter period holds at least two entries.
module wg_sine_rom #(
    parameter int PHASE_W  = 8,
    parameter int SAMPLE_W = 8
) (
    input  logic [PHASE_W-1:0]         phase_i,
    output logic signed [SAMPLE_W-1:0] sample_o
);

    localparam int DEPTH = 1 << PHASE_W;
    localparam int AMP   = (1 << (SAMPLE_W - 1)) - 1;

    logic signed [SAMPLE_W-1:0] entry_w [DEPTH];

    // Purpose: one constant per table slot, each computed at elaboration
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        localparam logic signed [SAMPLE_W-1:0] VALUE =
            SAMPLE_W'(wg_pkg::sine_sample(g, PHASE_W, AMP));
        assign entry_w[g] = VALUE;
    end

    assign sample_o = entry_w[phase_i];

endmodule

// File: rtl/wg_square_shaper.sv
// Module: two-level comparator for square mode.
// Emits LOW below THRESH and HIGH at or above it; purely combinational.
// Assumes THRESH lies inside the phase range.
module wg_square_shaper #(
    parameter int PHASE_W  = 8,
    parameter int SAMPLE_W = 8,
    parameter int THRESH   = 128
) (
    input  logic [PHASE_W-1:0]         phase_i,
    output logic signed [SAMPLE_W-1:0] level_o
);

    localparam int AMP = (1 << (SAMPLE_W - 1)) - 1;
    localparam logic signed [SAMPLE_W-1:0] LEVEL_HI = SAMPLE_W'(AMP);
    localparam logic signed [SAMPLE_W-1:0] LEVEL_LO = SAMPLE_W'(-AMP);
    localparam logic [PHASE_W-1:0] THRESH_P = PHASE_W'(THRESH);

    // Purpose: pick the fixed level from the phase position
    always_comb begin
        if (phase_i < THRESH_P) begin
            level_o = LEVEL_LO;
        end else begin
            level_o = LEVEL_HI;
        end
    end

endmodule

// File: rtl/dual_wave_gen.sv
// Module: sine / square sample generator top.
// A synchronized local clear drives a phase counter; the phase feeds a sine
// table and a square comparator; mode_sel picks one into an output register.
// Assumes mode_sel is synchronous to clk.
module dual_wave_gen #(
    parameter int PHASE_W    = 8,
    parameter int SAMPLE_W   = 8,
    parameter int RST_STAGES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_sel,
    output logic [SAMPLE_W-1:0] sample_out
);

    localparam int THRESH = 1 << (PHASE_W - 1);
    localparam int AMP    = (1 << (SAMPLE_W - 1)) - 1;

    logic                       loc_clr;
    logic [PHASE_W-1:0]         phase_w;
    logic signed [SAMPLE_W-1:0] sine_w;
    logic signed [SAMPLE_W-1:0] square_w;
    logic signed [SAMPLE_W-1:0] sample_q;
    wg_pkg::wave_mode_e         mode_e;

    assign mode_e = wg_pkg::wave_mode_e'(mode_sel);

    wg_reset_sync #(.STAGES(RST_STAGES)) u_rst_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_o (loc_clr)
    );

    wg_phase_counter #(.PHASE_W(PHASE_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (loc_clr),
        .phase_o (phase_w)
    );

    wg_sine_rom #(.PHASE_W(PHASE_W), .SAMPLE_W(SAMPLE_W)) u_sine (
        .phase_i  (phase_w),
        .sample_o (sine_w)
    );

    wg_square_shaper #(.PHASE_W(PHASE_W), .SAMPLE_W(SAMPLE_W), .THRESH(THRESH)) u_square (
        .phase_i (phase_w),
        .level_o (square_w)
    );

    // Purpose: register the selected waveform, forcing zero under local clear
    always_ff @(posedge clk) begin
        if (loc_clr) begin
            sample_q <= '0;
        end else if (mode_e == wg_pkg::MODE_SINE) begin
            sample_q <= sine_w;
        end else begin
            sample_q <= square_w;
        end
    end

    assign sample_out = sample_q;

    // R1: a cleared edge yields a zero sample
    assert_output_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(loc_clr) |-> sample_q == '0);

    // R5: square samples follow the phase held before the edge
    assert_square_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(loc_clr) && !$past(mode_sel)) |->
        int'(sample_q) == (int'($past(phase_w)) < THRESH ? -AMP : AMP));

    // R9: the most negative code is never produced
    assert_no_min_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sample_q != {1'b1, {(SAMPLE_W-1){1'b0}}});

endmodule

// File: tb/dual_wave_gen_tb_top.sv
module dual_wave_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_sel = 1'b0;
    logic [7:0] sample_out;

    always #5 clk = ~clk;

    dual_wave_gen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel   (mode_sel),
        .sample_out (sample_out)
    );

    int    total = 0;
    int    bad = 0;
    bit    finished = 1'b0;
    bit    m_live = 1'b0;
    string cur_tag = "R1";

    // reference model state
    int m_hold = 4;
    int m_phase = 0;
    int m_out = 0;
    int m_out_phase = 0;
    bit m_sine = 1'b0;
    int cap [256];
    bit capd [256];

    function automatic int ref_sine(input int p);
        real r;
        r = 127.0 * $sin(2.0 * 3.14159265358979 * real'(p) / 256.0);
        if (r >= 0.0) return $rtoi(r + 0.5);
        return -$rtoi(-r + 0.5);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // async reset entry seen by the model (R2 glitch case)
    always @(negedge rst_n) m_hold = 4;

    // behavioural model: one expected sample per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_hold = 4; m_out = 0; m_phase = 0; m_sine = 1'b0;
        end else if (m_hold > 0) begin
            m_hold--; m_out = 0; m_phase = 0; m_sine = 1'b0;
        end else begin
            m_out_phase = m_phase;
            m_sine = mode_sel;
            m_out = mode_sel ? ref_sine(m_phase) : ((m_phase < 128) ? -127 : 127);
            m_phase = (m_phase + 1) % 256;
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        int a;
        if (m_live && !finished) begin
            a = int'($signed(sample_out));
            chk(a != -128, "R9", a, m_out);
            if (m_sine) begin
                chk((a - m_out) <= 1 && (m_out - a) <= 1, "R6", a, m_out);
                cap[m_out_phase] = a;
                capd[m_out_phase] = 1'b1;
            end else begin
                chk(a == m_out, cur_tag, a, m_out);
            end
        end
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin cap[i] = 0; capd[i] = 1'b0; end
        repeat (3) @(negedge clk);
        m_live = 1'b1;
        cur_tag = "R1";
        chk(sample_out == 8'h00, "R1", int'(sample_out), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        cur_tag = "R3 R5";
        repeat (300) @(negedge clk);
        mode_sel = 1'b1;
        repeat (300) @(negedge clk);
        cur_tag = "R4";
        for (int i = 0; i < 60; i++) begin
            if (i % 3 == 0) mode_sel = ~mode_sel;
            @(negedge clk);
        end
        mode_sel = 1'b0;
        cur_tag = "R2";
        @(negedge clk);
        #2 rst_n = 1'b0;
        #1 rst_n = 1'b1;
        repeat (12) @(negedge clk);
        cur_tag = "R1";
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        cur_tag = "R3 R5";
        mode_sel = 1'b1;
        repeat (270) @(negedge clk);
        for (int i = 0; i < 256; i++) chk(capd[i], "R6", int'(capd[i]), 1);
        chk(cap[0] == 0, "R7", cap[0], 0);
        chk(cap[64] == 127, "R7", cap[64], 127);
        chk(cap[128] == 0, "R7", cap[128], 0);
        chk(cap[192] == -127, "R7", cap[192], -127);
        for (int i = 1; i < 128; i++) chk(cap[i] == -cap[i+128], "R8", cap[i], -cap[i+128]);
        for (int i = 1; i < 64; i++) chk(cap[i] == cap[128-i], "R8", cap[i], cap[128-i]);
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

endmodule